// File: doc/BRIEF.md
# DMA Channel End-of-Transfer Controller

This block sequences the bus cycles of one DMA channel and decides when the channel stops. The channel moves data either as a read/write pair per transfer (dual-address) or as one write cycle per transfer (single), and either one transfer per request (normal) or a whole block of transfers per request (block). It holds the channel-active flag, a transfer counter and a remaining-in-block counter, and it raises an interrupt-request flag when a transfer end is worth reporting.

A channel stops for four reasons: the transfer counter steps from 1 to 0, a repeat-area overflow arrives with its interrupt enabled, software writes 0 to the active flag, or a non-maskable abort arrives. Stopping is always graceful. The write that follows a read is completed. Software stops and overflows wait for the block boundary. The active flag stays 1 until that wind-down is over, and it falls on the clock edge where the last write's done handshake is sampled. Bus cycles are strobes held high until `bus_done`. Address generation and arbitration between channels sit outside the block.

Top module: `dmt_top`

## Requirements
- R1: After synchronous reset, `act`, `irq`, `ack`, `bus_rd` and `bus_wr` are all 0.
- R2: A one-cycle `sw_act_wr` with `sw_act_val`=1 sets `act` only while `act`=0 and `irq`=0. If `irq`=1, the write is ignored and `act` stays 0. `cnt_load` copies `cnt_val` into `tcnt` only while `act`=0. While `act`=1 the load is ignored.
- R3: A dual-address transfer is a read cycle (`bus_rd`) followed by a write cycle (`bus_wr`). A single transfer is one write cycle with no read. Each strobe stays high until the edge on which `bus_done` is sampled.
- R4: In normal mode, `tcnt` decrements by one per completed transfer. When it steps from 1 to 0, the channel stops. `act` falls on the same edge that samples the final write's `bus_done`.
- R5: On a counter end with `cfg_tcie`=1, `irq` becomes 1. With `cfg_tcie`=0, it stays 0.
- R6: A transfer started with `tcnt`=0 does not stop at 0. The counter wraps to all ones and continues, so it ends after 2^CNT_W transfers (normal) or 2^BTC_W blocks (block).
- R7: In block mode, one accepted request runs `blk_size` transfers back to back. Only the low BTC_W bits of `tcnt` decrement, once per block, and the upper bits are unchanged. The end check uses the low bits only.
- R8: A `src_ovf` or `dst_ovf` pulse with its enable (`cfg_src_rie` / `cfg_dst_rie`) set stops the channel after the current transfer and sets `irq`. In dual-address mode, an overflow during the read still lets the write complete. An overflow whose enable is 0 has no effect.
- R9: In block mode, an enabled overflow raised partway through a block takes effect only after the last transfer of that block.
- R10: After software writes 0 to `act`, the channel finishes the transfer in progress (the whole block in block mode) before stopping. `act` reads 1 until then. If the channel is waiting for a request, `act` falls within two cycles.
- R11: An `nmi` pulse stops an active channel after the current read/write pair, even partway through a block. It does not set `irq`.
- R12: `irq` stays 1 until a `sw_irq_clr` pulse clears it.
- R13: When `cfg_ext`=1, `ack` pulses once for each accepted request, in the first cycle of its bus strobe. Every acknowledged transfer is completed, including when `nmi` arrives during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1: read+write per transfer; 0: single write cycle |
| cfg_block | input | 1 | 1: block mode |
| cfg_ext | input | 1 | 1: external request mode (acknowledge output used) |
| cfg_tcie | input | 1 | Counter-end interrupt enable |
| cfg_src_rie | input | 1 | Source repeat-overflow interrupt enable |
| cfg_dst_rie | input | 1 | Destination repeat-overflow interrupt enable |
| sw_act_wr | input | 1 | Software write strobe for the active flag |
| sw_act_val | input | 1 | Value written to the active flag |
| sw_irq_clr | input | 1 | Clears the interrupt-request flag |
| cnt_load | input | 1 | Loads the transfer counter |
| cnt_val | input | CNT_W | Value for the transfer counter |
| blk_size | input | BLK_W | Transfers per block |
| req | input | 1 | Transfer request |
| ack | output | 1 | Request acknowledge pulse |
| src_ovf | input | 1 | Source repeat-area overflow pulse |
| dst_ovf | input | 1 | Destination repeat-area overflow pulse |
| nmi | input | 1 | Non-maskable abort |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_done | input | 1 | Bus cycle done handshake |
| act | output | 1 | Channel-active flag |
| irq | output | 1 | Interrupt-request flag and interrupt line |
| tcnt | output | CNT_W | Transfer counter |

## Verification
The bench sweeps counts, block sizes, bus latencies and both transfer modes, and checks the exact number of read and write cycles and the final counter value in each case. An off-by-one in the counter end check would show up as one transfer too many or too few. It also checks that a zero start count runs a full wrap. It injects overflow, software stop and abort pulses at chosen reads inside blocks. A design that stopped at once would drop a pending write or cut a block short. One that used the wrong stop rule would show a wrong cycle count, a wrong `irq`, or `act` falling too early. The block-mode runs load a non-zero upper counter field, which catches a design that runs its end check or its decrement across the full counter width.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;

    typedef struct packed {
        logic sw;
        logic ovf;
        logic nmi;
    } halt_t;

endpackage

// File: rtl/dmt_cnt.sv
module dmt_cnt
    import dmt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int BTC_W = 16,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [BLK_W-1:0] blk_size,
    input  logic             blk_start,
    input  logic             unit_done,
    input  logic             in_blk,
    input  logic             boundary,
    output logic [CNT_W-1:0] tcnt,
    output logic             tc_last,
    output logic             blk_last
);

    logic [BLK_W-1:0] bcnt;
    logic [CNT_W-1:0] tc_next;
    logic [BTC_W-1:0] low_dec;

    always_comb begin
        low_dec = tcnt[BTC_W-1:0] - BTC_W'(1);
        tc_next = tcnt - CNT_W'(1);
        if (in_blk) begin
            tc_next = tcnt;
            tc_next[BTC_W-1:0] = low_dec;
        end
        tc_last  = in_blk ? (tcnt[BTC_W-1:0] == BTC_W'(1)) : (tcnt == CNT_W'(1));
        blk_last = (bcnt == BLK_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
            bcnt <= '0;
        end else begin
            if (cnt_load && !act)
                tcnt <= cnt_val;
            else if (boundary)
                tcnt <= tc_next;
            if (blk_start)
                bcnt <= blk_size;
            else if (unit_done && in_blk)
                bcnt <= bcnt - BLK_W'(1);
        end
    end

    // R2 / R4: while the channel runs, the counter moves only on a transfer end
    a_r4_count_only_at_end: assert property (@(posedge clk) disable iff (rst)
        (act && !boundary) |=> $stable(tcnt));

    generate
        if (BTC_W < CNT_W) begin : g_upper
            // R7: block mode leaves the upper counter field untouched
            a_r7_upper_hold: assert property (@(posedge clk) disable iff (rst)
                (act && in_blk) |=> $stable(tcnt[CNT_W-1:BTC_W]));
        end
    endgenerate

endmodule

// File: rtl/dmt_seq.sv
module dmt_seq
    import dmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_dual,
    input  logic cfg_block,
    input  logic cfg_ext,
    input  logic act,
    input  logic halt,
    input  logic finish,
    input  logic req,
    input  logic bus_done,
    input  logic blk_last,
    output logic idle,
    output logic accept,
    output logic unit_done,
    output logic boundary,
    output logic in_blk,
    output logic ack,
    output logic bus_rd,
    output logic bus_wr
);

    phase_e ph;
    logic   dual_q;

    always_comb begin
        idle      = (ph == PH_IDLE);
        accept    = act && idle && req && !halt;
        unit_done = (ph == PH_WR) && bus_done;
        boundary  = unit_done && (!in_blk || blk_last);
        bus_rd    = (ph == PH_RD);
        bus_wr    = (ph == PH_WR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            dual_q <= 1'b0;
            in_blk <= 1'b0;
            ack    <= 1'b0;
        end else begin
            ack <= accept && cfg_ext;
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        dual_q <= cfg_dual;
                        in_blk <= cfg_block;
                        ph     <= cfg_dual ? PH_RD : PH_WR;
                    end
                end
                PH_RD: begin
                    if (bus_done)
                        ph <= PH_WR;
                end
                PH_WR: begin
                    if (bus_done) begin
                        if (finish || !in_blk || blk_last) begin
                            ph     <= PH_IDLE;
                            in_blk <= 1'b0;
                        end else begin
                            ph <= dual_q ? PH_RD : PH_WR;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R3: a read strobe is held until its done handshake
    a_r3_rd_held: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_done) |=> bus_rd);
    // R3: a completed read is always followed by its write
    a_r3_wr_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_done) |=> bus_wr);
    // R13: an acknowledge coincides with the start of a bus cycle
    a_r13_ack_with_cycle: assert property (@(posedge clk) disable iff (rst)
        ack |-> (bus_rd || bus_wr));
    // R9: inside a block, transfers continue without a gap
    a_r9_block_no_gap: assert property (@(posedge clk) disable iff (rst)
        (in_blk && unit_done && !blk_last && !finish) |=> (bus_rd || bus_wr));

endmodule

// File: rtl/dmt_term.sv
module dmt_term
    import dmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_tcie,
    input  logic cfg_src_rie,
    input  logic cfg_dst_rie,
    input  logic sw_act_wr,
    input  logic sw_act_val,
    input  logic sw_irq_clr,
    input  logic src_ovf,
    input  logic dst_ovf,
    input  logic nmi,
    input  logic idle,
    input  logic unit_done,
    input  logic boundary,
    input  logic tc_last,
    output logic act,
    output logic irq,
    output logic halt,
    output logic finish
);

    halt_t pend;
    logic  ovf_hit, ovf_now, nmi_now, tc_end, irq_set, start;

    always_comb begin
        ovf_hit = act && ((src_ovf && cfg_src_rie) || (dst_ovf && cfg_dst_rie));
        ovf_now = pend.ovf || ovf_hit;
        nmi_now = pend.nmi || nmi;
        halt    = pend.sw || ovf_now || nmi_now;
        tc_end  = boundary && tc_last;
        finish  = act && ((idle && halt)
                       || (unit_done && nmi_now)
                       || (boundary && (tc_last || pend.sw || ovf_now)));
        irq_set = finish && ((tc_end && cfg_tcie) || (ovf_now && (idle || boundary)));
        start   = sw_act_wr && sw_act_val && !act && !irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            irq  <= 1'b0;
            pend <= '0;
        end else begin
            if (finish) begin
                act  <= 1'b0;
                pend <= '0;
            end else if (start) begin
                act  <= 1'b1;
                pend <= '0;
            end else if (act) begin
                if (sw_act_wr && !sw_act_val) pend.sw  <= 1'b1;
                if (ovf_hit)                  pend.ovf <= 1'b1;
                if (nmi)                      pend.nmi <= 1'b1;
            end
            if (irq_set)
                irq <= 1'b1;
            else if (sw_irq_clr)
                irq <= 1'b0;
        end
    end

    // R10: the active flag drops only while waiting or on a write completion
    a_r10_fall_point: assert property (@(posedge clk) disable iff (rst)
        $fell(act) |-> $past(idle || unit_done));
    // R12: the request flag clears only on software request
    a_r12_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(sw_irq_clr));
    // R11: an abort while waiting for a request stops the channel at once
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (act && idle && nmi) |=> !act);
    // R2: a start write is ignored while the request flag is set
    a_r2_no_start_irq: assert property (@(posedge clk) disable iff (rst)
        (!act && irq) |=> !act);

endmodule

// File: rtl/dmt_top.sv
module dmt_top
    import dmt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int BTC_W = 16,
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_dual,
    input  logic             cfg_block,
    input  logic             cfg_ext,
    input  logic             cfg_tcie,
    input  logic             cfg_src_rie,
    input  logic             cfg_dst_rie,
    input  logic             sw_act_wr,
    input  logic             sw_act_val,
    input  logic             sw_irq_clr,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [BLK_W-1:0] blk_size,
    input  logic             req,
    output logic             ack,
    input  logic             src_ovf,
    input  logic             dst_ovf,
    input  logic             nmi,
    output logic             bus_rd,
    output logic             bus_wr,
    input  logic             bus_done,
    output logic             act,
    output logic             irq,
    output logic [CNT_W-1:0] tcnt
);

    logic idle, accept, unit_done, boundary, in_blk;
    logic halt, finish, tc_last, blk_last, blk_start;

    assign blk_start = accept && cfg_block;

    dmt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_dual  (cfg_dual),
        .cfg_block (cfg_block),
        .cfg_ext   (cfg_ext),
        .act       (act),
        .halt      (halt),
        .finish    (finish),
        .req       (req),
        .bus_done  (bus_done),
        .blk_last  (blk_last),
        .idle      (idle),
        .accept    (accept),
        .unit_done (unit_done),
        .boundary  (boundary),
        .in_blk    (in_blk),
        .ack       (ack),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr)
    );

    dmt_cnt #(
        .CNT_W (CNT_W),
        .BTC_W (BTC_W),
        .BLK_W (BLK_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .blk_size  (blk_size),
        .blk_start (blk_start),
        .unit_done (unit_done),
        .in_blk    (in_blk),
        .boundary  (boundary),
        .tcnt      (tcnt),
        .tc_last   (tc_last),
        .blk_last  (blk_last)
    );

    dmt_term u_term (
        .clk         (clk),
        .rst         (rst),
        .cfg_tcie    (cfg_tcie),
        .cfg_src_rie (cfg_src_rie),
        .cfg_dst_rie (cfg_dst_rie),
        .sw_act_wr   (sw_act_wr),
        .sw_act_val  (sw_act_val),
        .sw_irq_clr  (sw_irq_clr),
        .src_ovf     (src_ovf),
        .dst_ovf     (dst_ovf),
        .nmi         (nmi),
        .idle        (idle),
        .unit_done   (unit_done),
        .boundary    (boundary),
        .tc_last     (tc_last),
        .act         (act),
        .irq         (irq),
        .halt        (halt),
        .finish      (finish)
    );

endmodule

// File: tb/sim_dmt_top.sv
module sim_dmt_top;

    localparam int CW = 8;
    localparam int TW = 4;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_dual = 0, cfg_block = 0, cfg_ext = 0, cfg_tcie = 0;
    logic cfg_src_rie = 0, cfg_dst_rie = 0;
    logic t_sw_wr = 0, t_sw_val = 0, r_sw = 0;
    logic sw_act_wr, sw_act_val;
    logic sw_irq_clr = 0, cnt_load = 0, req = 0;
    logic [CW-1:0] cnt_val = '0;
    logic [BW-1:0] blk_size = '0;
    logic src_ovf = 0, dst_ovf = 0, r_nmi = 0, bus_done = 0;
    logic ack, bus_rd, bus_wr, act, irq;
    logic [CW-1:0] tcnt;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int rd_n = 0, wr_n = 0, ack_n = 0, lat = 0, wait_c = 0;
    int inj_kind = 0, inj_num = 0;
    logic inj_wr = 0;
    logic last_act_at = 0, last_act_after = 0, sw_seen = 0;

    assign sw_act_wr  = t_sw_wr | r_sw;
    assign sw_act_val = r_sw ? 1'b0 : t_sw_val;

    always #10 clk = ~clk;

    dmt_top #(.CNT_W(CW), .BTC_W(TW), .BLK_W(BW)) u0 (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_block(cfg_block),
        .cfg_ext(cfg_ext), .cfg_tcie(cfg_tcie), .cfg_src_rie(cfg_src_rie),
        .cfg_dst_rie(cfg_dst_rie), .sw_act_wr(sw_act_wr), .sw_act_val(sw_act_val),
        .sw_irq_clr(sw_irq_clr), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .blk_size(blk_size), .req(req), .ack(ack), .src_ovf(src_ovf),
        .dst_ovf(dst_ovf), .nmi(r_nmi), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_done(bus_done), .act(act), .irq(irq), .tcnt(tcnt)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
                finish_run();
            end
        end
    end

    // bus responder and stimulus injector, all changes at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (ack) ack_n++;
            if (bus_done) begin
                bus_done = 0;
                last_act_after = act;
                if (r_sw) sw_seen = act;
                src_ovf = 0; dst_ovf = 0; r_nmi = 0; r_sw = 0;
            end else if (bus_rd || bus_wr) begin
                if (wait_c >= lat) begin
                    bus_done = 1;
                    wait_c = 0;
                    if (bus_wr) begin wr_n++; last_act_at = act; end
                    else rd_n++;
                    if (inj_kind != 0 && inj_wr == bus_wr &&
                        inj_num == (bus_wr ? wr_n : rd_n)) begin
                        case (inj_kind)
                            1: src_ovf = 1;
                            2: dst_ovf = 1;
                            3: r_nmi = 1;
                            default: r_sw = 1;
                        endcase
                    end
                end else begin
                    wait_c++;
                end
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_irq();
        sw_irq_clr = 1;
        tick(1);
        sw_irq_clr = 0;
        tick(1);
    endtask

    task automatic run(input logic dual, input logic blk, input logic ext,
                       input logic tcie, input int cnt, input int bsz, input int l);
        int guard;
        cfg_dual = dual; cfg_block = blk; cfg_ext = ext; cfg_tcie = tcie;
        blk_size = BW'(bsz); lat = l;
        rd_n = 0; wr_n = 0; ack_n = 0; wait_c = 0;
        cnt_load = 1; cnt_val = CW'(cnt);
        tick(1);
        cnt_load = 0; t_sw_wr = 1; t_sw_val = 1;
        tick(1);
        t_sw_wr = 0; req = 1;
        guard = 0;
        while (act && guard < 5000) begin
            tick(1);
            guard++;
        end
        req = 0;
        if (guard >= 5000) check("run timeout", guard, 0);
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        check("R1 act", act, 0);
        check("R1 irq", irq, 0);
        check("R1 ack", ack, 0);
        check("R1 rd", bus_rd, 0);
        check("R1 wr", bus_wr, 0);

        // R3 R4 R5: normal-mode sweep over mode, count and latency
        for (int d = 0; d < 2; d++)
            for (int c = 1; c <= 6; c++)
                for (int l = 0; l < 3; l++) begin
                    run(d[0], 0, 1, c[0], c, 1, l);
                    check("R4 writes", wr_n, c);
                    check("R3 reads", rd_n, d == 1 ? c : 0);
                    check("R4 tcnt", tcnt, 0);
                    check("R4 act at final done", last_act_at, 1);
                    check("R4 act after final done", last_act_after, 0);
                    check("R5 irq", irq, c % 2);
                    check("R13 acks", ack_n, c);
                    if (irq) clear_irq();
                end

        // R7: block sweep with a non-zero upper counter field
        for (int d = 0; d < 2; d++)
            for (int c = 1; c <= 3; c++)
                for (int b = 1; b <= 4; b++) begin
                    run(d[0], 1, 1, 1, 'hA0 + c, b, 0);
                    check("R7 writes", wr_n, c * b);
                    check("R7 reads", rd_n, d == 1 ? c * b : 0);
                    check("R7 tcnt", tcnt, 'hA0);
                    check("R7 acks", ack_n, c);
                    check("R5 irq block", irq, 1);
                    clear_irq();
                end

        // R6: zero start wraps
        run(0, 0, 0, 0, 0, 1, 0);
        check("R6 normal wrap writes", wr_n, 256);
        check("R6 normal wrap tcnt", tcnt, 0);
        run(1, 1, 0, 0, 'h50, 1, 0);
        check("R6 block wrap writes", wr_n, 16);
        check("R6 block wrap tcnt", tcnt, 'h50);

        // R8: enabled source overflow during read 3, write still done
        cfg_src_rie = 1; inj_kind = 1; inj_wr = 0; inj_num = 3;
        run(1, 0, 0, 0, 10, 1, 1);
        check("R8 writes", wr_n, 3);
        check("R8 reads", rd_n, 3);
        check("R8 tcnt", tcnt, 7);
        check("R8 irq", irq, 1);
        clear_irq();
        // R8: disabled overflow ignored
        cfg_src_rie = 0;
        run(1, 0, 0, 0, 5, 1, 0);
        check("R8 disabled writes", wr_n, 5);
        check("R8 disabled irq", irq, 0);

        // R9: overflow mid-block finishes the block
        cfg_src_rie = 1; inj_num = 2;
        run(1, 1, 0, 0, 'hA5, 4, 0);
        check("R9 src writes", wr_n, 4);
        check("R9 src tcnt", tcnt, 'hA4);
        check("R9 src irq", irq, 1);
        clear_irq();
        cfg_src_rie = 0; cfg_dst_rie = 1; inj_kind = 2; inj_wr = 1; inj_num = 6;
        run(1, 1, 0, 0, 'hA5, 4, 0);
        check("R9 dst writes", wr_n, 8);
        check("R9 dst tcnt", tcnt, 'hA3);
        check("R9 dst irq", irq, 1);
        clear_irq();
        cfg_dst_rie = 0;

        // R11 R13: abort mid-block and in normal mode, acknowledged work done
        inj_kind = 3; inj_wr = 0; inj_num = 2;
        run(1, 1, 1, 1, 'hA5, 4, 0);
        check("R11 block writes", wr_n, 2);
        check("R11 block reads", rd_n, 2);
        check("R11 block tcnt", tcnt, 'hA5);
        check("R11 block irq", irq, 0);
        check("R13 block acks", ack_n, 1);
        inj_num = 3;
        run(1, 0, 1, 1, 10, 1, 1);
        check("R11 normal writes", wr_n, 3);
        check("R11 normal tcnt", tcnt, 7);
        check("R11 normal irq", irq, 0);
        check("R13 normal acks", ack_n, 3);

        // R10: software stop
        inj_kind = 4; inj_num = 4;
        run(1, 0, 0, 0, 10, 1, 0);
        check("R10 normal writes", wr_n, 4);
        check("R10 normal tcnt", tcnt, 6);
        check("R10 normal act held", sw_seen, 1);
        inj_num = 2;
        run(1, 1, 0, 0, 'hA5, 4, 0);
        check("R10 block writes", wr_n, 4);
        check("R10 block tcnt", tcnt, 'hA4);
        check("R10 block act held", sw_seen, 1);
        inj_kind = 0;

        // R2 R10: load ignored while active; idle stop within two cycles
        cnt_load = 1; cnt_val = 8'h33;
        tick(1);
        cnt_load = 0; t_sw_wr = 1; t_sw_val = 1;
        tick(1);
        t_sw_wr = 0;
        check("R2 start", act, 1);
        cnt_load = 1; cnt_val = 8'h77;
        tick(1);
        cnt_load = 0;
        tick(1);
        check("R2 load ignored", tcnt, 'h33);
        t_sw_wr = 1; t_sw_val = 0;
        tick(1);
        t_sw_wr = 0;
        tick(1);
        check("R10 idle stop", act, 0);
        check("R10 idle no cycles", bus_wr, 0);

        // R12 R2: sticky flag blocks a restart
        run(0, 0, 0, 1, 2, 1, 0);
        check("R5 irq set", irq, 1);
        tick(5);
        check("R12 irq held", irq, 1);
        t_sw_wr = 1; t_sw_val = 1;
        tick(1);
        t_sw_wr = 0;
        tick(2);
        check("R2 start blocked by irq", act, 0);
        clear_irq();
        check("R12 irq cleared", irq, 0);
        run(0, 0, 0, 0, 2, 1, 0);
        check("R2 restart after clear", wr_n, 2);

        finish_run();
    end

endmodule